// File: doc/BRIEF.md
# Multi-Pass Attribute Evaluator

This block decorates a parse tree that has already been built. Each tree node carries a rule code, a link to its parent, links to up to two children and a constant. Every node owns two attribute slots: a synthesized value, computed from its children (or from its own inherited value), and an inherited value, computed from its parent or its left sibling. Each slot holds a value and a valid bit. The rule code of a node selects the small arithmetic unit that computes the synthesized value. A second code selects how the inherited value is formed.

After the tree is loaded and `start` is pulsed, the block walks the tree top-down and left to right, visiting the inherited slot of a node before its synthesized slot. It computes any slot whose operands are already valid. A pass that meets a slot it cannot yet compute is marked incomplete. Passes repeat until one finishes with nothing left undone. The block reports the root's synthesized value, the number of passes used, and an error when the dependencies cannot be resolved: a pass that makes no progress, or a pass limit that runs out.

Top module: `attr_eval`

## Requirements
- R1: After reset, `busy`, `done` and `error` are 0, and `passes` and `result` are 0.
- R2: A pass visits nodes in preorder, first child before second child. Within a node, the inherited slot is handled one cycle before the synthesized slot. A value written earlier in a pass is usable later in the same pass.
- R3: At the end, `done` is high for exactly one cycle and `busy` falls at the same time. `result` (the root's synthesized value, or 0 on error), `passes` and `error` hold until the next start.
- R4: The synthesized rule codes are:
  - 0: the node's constant, valid from the start of the run.
  - 1: copy of child0.
  - 2: child0 + child1.
  - 3: child0 * child1.
  - 4: 10*child0 + child1.
  - 5: own inherited + 1.
  - 6: copy of own inherited.
  - 7: copy of child1.

  All arithmetic wraps modulo 2^W.
- R5: The inherited mode codes are:
  - 0: no inherited attribute. The slot is valid from the start of the run with value 0.
  - 1: parent inherited + 1.
  - 2: synthesized value of the parent's child0 (the left sibling).
  - 3: copy of parent inherited.
- R6: Each pass starts with the completion flag set. A slot that cannot be computed clears the flag. Passes repeat until a pass ends with the flag set. For a chain of k copy nodes above a constant, `passes` equals k.
- R7: A pass that ends incomplete and wrote no new slot ends the run with `error`=1. `passes` then counts that pass.
- R8: If pass number MAX_PASSES ends incomplete, the run ends with `error`=1 and `passes`=MAX_PASSES. A tree that completes in exactly MAX_PASSES passes succeeds.
- R9: For a tree whose root is a single constant node, `done` rises on the third rising edge after the edge that samples `start`.
- R10: `start` clears `error`, clears every non-constant valid bit and rearms the pass count. Rerunning the same tree gives the same `passes` and `result`.
- R11: Node 0 is the root. A child field of 0 means no child. Tree load writes are accepted only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one tree node |
| ld_node | input | AW | Node index being written |
| ld_rule | input | 3 | Synthesized rule code |
| ld_inh | input | 2 | Inherited mode code |
| ld_parent | input | AW | Parent index |
| ld_child0 | input | AW | First child index, 0 = none |
| ld_child1 | input | AW | Second child index, 0 = none |
| ld_const | input | W | Constant for rule 0 |
| start | input | 1 | Begin evaluation (accepted while idle) |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Unresolvable dependencies |
| passes | output | PW | Number of passes performed |
| result | output | W | Root synthesized value |

## Verification
The one fixed latency is the single-node case. There `done` is sampled low after the first and second edges following the start edge and high after the third. For larger trees the run length depends on tree shape. The bench therefore polls `done` on falling edges and reads `result`, `passes` and `error` in that same half cycle, which R3 defines as valid. It then samples once more a cycle later to confirm that `done` has dropped while the other outputs hold. The expected pass counts come from the height of each tree and the preorder visiting rule: three for the product tree, two for the inherited chain, where the same-pass reuse saves a pass, and one or MAX_PASSES for the error cases.

// File: rtl/attr_eval.sv
module attr_eval #(
  parameter int NODES      = 16,
  parameter int W          = 16,
  parameter int MAX_PASSES = 8,
  localparam int AW = $clog2(NODES),
  localparam int PW = $clog2(MAX_PASSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_node,
  input  logic [2:0]    ld_rule,
  input  logic [1:0]    ld_inh,
  input  logic [AW-1:0] ld_parent,
  input  logic [AW-1:0] ld_child0,
  input  logic [AW-1:0] ld_child1,
  input  logic [W-1:0]  ld_const,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [PW-1:0] passes,
  output logic [W-1:0]  result
);

  localparam logic [2:0] RU_CONST = 3'd0, RU_COPY0 = 3'd1, RU_ADD = 3'd2, RU_MUL = 3'd3,
                         RU_DIGIT = 3'd4, RU_INC  = 3'd5, RU_CINH = 3'd6, RU_COPY1 = 3'd7;
  localparam logic [1:0] IM_NONE = 2'd0, IM_PINC = 2'd1, IM_LSIB = 2'd2, IM_PCOPY = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_INH, S_SYN, S_CLIMB} state_t;
  state_t state;

  logic [2:0]    rule_m  [NODES];
  logic [1:0]    inh_m   [NODES];
  logic [AW-1:0] par_m   [NODES];
  logic [AW-1:0] ch0_m   [NODES];
  logic [AW-1:0] ch1_m   [NODES];
  logic [W-1:0]  const_m [NODES];

  logic [W-1:0]     syn_v [NODES];
  logic [W-1:0]     inh_v [NODES];
  logic [NODES-1:0] syn_ok, inh_ok;

  logic [AW-1:0] cur;
  logic          complete, progress;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (ld_en && state == S_IDLE) begin
      rule_m[ld_node]  <= ld_rule;
      inh_m[ld_node]   <= ld_inh;
      par_m[ld_node]   <= ld_parent;
      ch0_m[ld_node]   <= ld_child0;
      ch1_m[ld_node]   <= ld_child1;
      const_m[ld_node] <= ld_const;
    end
  end

  wire [AW-1:0] c0   = ch0_m[cur];
  wire [AW-1:0] c1   = ch1_m[cur];
  wire [AW-1:0] par  = par_m[cur];
  wire [AW-1:0] lsib = ch0_m[par];
  wire [W-1:0]  a    = syn_v[c0];
  wire [W-1:0]  b    = syn_v[c1];
  wire          both = syn_ok[c0] && syn_ok[c1];

  logic          inh_rdy, syn_rdy;
  logic [W-1:0]  inh_new, syn_new;

  always_comb begin
    inh_rdy = 1'b1;
    inh_new = '0;
    case (inh_m[cur])
      IM_PINC:  begin inh_rdy = inh_ok[par];   inh_new = inh_v[par] + W'(1); end
      IM_LSIB:  begin inh_rdy = syn_ok[lsib];  inh_new = syn_v[lsib];        end
      IM_PCOPY: begin inh_rdy = inh_ok[par];   inh_new = inh_v[par];         end
      default:  begin inh_rdy = 1'b1;          inh_new = '0;                 end
    endcase
  end

  always_comb begin
    syn_rdy = 1'b1;
    syn_new = const_m[cur];
    case (rule_m[cur])
      RU_COPY0: begin syn_rdy = syn_ok[c0];  syn_new = a;                    end
      RU_ADD:   begin syn_rdy = both;        syn_new = a + b;                end
      RU_MUL:   begin syn_rdy = both;        syn_new = a * b;                end
      RU_DIGIT: begin syn_rdy = both;        syn_new = a * W'(10) + b;       end
      RU_INC:   begin syn_rdy = inh_ok[cur]; syn_new = inh_v[cur] + W'(1);   end
      RU_CINH:  begin syn_rdy = inh_ok[cur]; syn_new = inh_v[cur];           end
      RU_COPY1: begin syn_rdy = syn_ok[c1];  syn_new = b;                    end
      default:  begin syn_rdy = 1'b1;        syn_new = const_m[cur];         end
    endcase
  end

  wire at_limit = (passes == PW'(MAX_PASSES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur      <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
      passes   <= '0;
      result   <= '0;
      complete <= 1'b0;
      progress <= 1'b0;
      syn_ok   <= '0;
      inh_ok   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          for (int k = 0; k < NODES; k++) begin
            syn_ok[k] <= (rule_m[k] == RU_CONST);
            syn_v[k]  <= const_m[k];
            inh_ok[k] <= (inh_m[k] == IM_NONE);
            inh_v[k]  <= '0;
          end
          cur      <= '0;
          passes   <= PW'(1);
          complete <= 1'b1;
          progress <= 1'b0;
          error    <= 1'b0;
          state    <= S_INH;
        end
        S_INH: begin
          if (!inh_ok[cur]) begin
            if (inh_rdy) begin
              inh_ok[cur] <= 1'b1;
              inh_v[cur]  <= inh_new;
              progress    <= 1'b1;
            end else complete <= 1'b0;
          end
          state <= S_SYN;
        end
        S_SYN: begin
          if (!syn_ok[cur]) begin
            if (syn_rdy) begin
              syn_ok[cur] <= 1'b1;
              syn_v[cur]  <= syn_new;
              progress    <= 1'b1;
            end else complete <= 1'b0;
          end
          if (c0 != '0) begin
            cur   <= c0;
            state <= S_INH;
          end else state <= S_CLIMB;
        end
        S_CLIMB: begin
          if (cur == '0) begin
            if (complete) begin
              done   <= 1'b1;
              result <= syn_v[0];
              state  <= S_IDLE;
            end else if (!progress || at_limit) begin
              done   <= 1'b1;
              error  <= 1'b1;
              result <= '0;
              state  <= S_IDLE;
            end else begin
              passes   <= passes + PW'(1);
              complete <= 1'b1;
              progress <= 1'b0;
              state    <= S_INH;
            end
          end else if (ch0_m[par] == cur && ch1_m[par] != '0) begin
            cur   <= ch1_m[par];
            state <= S_INH;
          end else cur <= par;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_root_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> syn_ok[0]);
  assert_error_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);
  assert_pass_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    passes <= PW'(MAX_PASSES));
  assert_pass_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && passes != $past(passes)) |-> passes == $past(passes) + PW'(1));

endmodule

// File: tb/attr_eval_tb.sv
module attr_eval_tb;
  localparam int NODES = 16, W = 16, MAXP = 8;
  localparam int AW = $clog2(NODES), PW = $clog2(MAXP + 1);

  localparam logic [2:0] CONST = 3'd0, COPY0 = 3'd1, ADD = 3'd2, MUL = 3'd3,
                         DIGIT = 3'd4, INC = 3'd5, CINH = 3'd6;
  localparam logic [1:0] NONE = 2'd0, PINC = 2'd1, LSIB = 2'd2;

  logic clk = 0, rst_n = 0, ld_en = 0, start = 0;
  logic [AW-1:0] ld_node = 0, ld_parent = 0, ld_child0 = 0, ld_child1 = 0;
  logic [2:0] ld_rule = 0;
  logic [1:0] ld_inh = 0;
  logic [W-1:0] ld_const = 0;
  logic busy, done, error;
  logic [PW-1:0] passes;
  logic [W-1:0] result;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  attr_eval #(.NODES(NODES), .W(W), .MAX_PASSES(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_node(ld_node), .ld_rule(ld_rule),
    .ld_inh(ld_inh), .ld_parent(ld_parent), .ld_child0(ld_child0), .ld_child1(ld_child1),
    .ld_const(ld_const), .start(start), .busy(busy), .done(done), .error(error),
    .passes(passes), .result(result));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic node(int n, logic [2:0] r, logic [1:0] im, int p, int a, int b, int k);
    @(negedge clk);
    ld_en = 1; ld_node = AW'(n); ld_rule = r; ld_inh = im;
    ld_parent = AW'(p); ld_child0 = AW'(a); ld_child1 = AW'(b); ld_const = W'(k);
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic run(string tag);
    int n = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    check({tag, " done seen"}, int'(done), 1);
  endtask

  task automatic after_done(string tag, int res, int p, int e);
    check({tag, " R3 result"}, int'(result), res);
    check({tag, " R6 passes"}, int'(passes), p);
    check({tag, " R7 error"}, int'(error), e);
    @(negedge clk);
    check({tag, " R3 done pulse"}, int'(done), 0);
    check({tag, " R3 result hold"}, int'(result), res);
  endtask

  task automatic t_reset;
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 error", int'(error), 0);
    check("R1 passes", int'(passes), 0);
    check("R1 result", int'(result), 0);
  endtask

  task automatic t_single;
    node(0, CONST, NONE, 0, 0, 0, 77);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); check("R9 edge1", int'(done), 0);
    @(negedge clk); check("R9 edge2", int'(done), 0);
    @(negedge clk); check("R9 edge3", int'(done), 1);
    after_done("R9 single", 77, 1, 0);
  endtask

  task automatic load_expr;
    node(0, COPY0, NONE, 0, 1, 0, 0);
    node(1, MUL,   NONE, 0, 2, 5, 0);
    node(2, DIGIT, NONE, 1, 3, 4, 0);
    node(3, CONST, NONE, 2, 0, 0, 3);
    node(4, CONST, NONE, 2, 0, 0, 5);
    node(5, CONST, NONE, 1, 0, 0, 4);
  endtask

  task automatic t_expr;
    load_expr();
    run("R4 expr");
    after_done("R4 R11 expr 35*4", 140, 3, 0);
  endtask

  task automatic t_inherit;
    node(0, ADD,  NONE, 0, 1, 2, 0);
    node(1, INC,  PINC, 0, 0, 0, 0);
    node(2, CINH, LSIB, 0, 0, 0, 0);
    run("R5 inh");
    after_done("R2 R5 same-pass reuse", 4, 2, 0);
  endtask

  task automatic t_circular;
    node(0, ADD,   NONE, 0, 1, 2, 0);
    node(1, INC,   LSIB, 0, 0, 0, 0);
    node(2, CONST, NONE, 0, 0, 0, 9);
    run("R7 circ");
    after_done("R7 no progress", 0, 1, 1);
  endtask

  task automatic load_chain(int k);
    for (int i = 0; i < k; i++) node(i, COPY0, NONE, (i == 0) ? 0 : i - 1, i + 1, 0, 0);
    node(k, CONST, NONE, k - 1, 0, 0, 1234);
  endtask

  task automatic t_limit;
    load_chain(MAXP);
    run("R8 ok");
    after_done("R8 exactly limit", 1234, MAXP, 0);
    load_chain(MAXP + 1);
    run("R8 over");
    after_done("R8 over limit", 0, MAXP, 1);
  endtask

  task automatic t_wrap;
    node(0, MUL,   NONE, 0, 1, 2, 0);
    node(1, CONST, NONE, 0, 0, 0, 300);
    node(2, CONST, NONE, 0, 0, 0, 300);
    run("R4 wrap");
    after_done("R4 mul wrap", (300 * 300) % 65536, 1, 0);
  endtask

  task automatic t_rerun;
    load_expr();
    run("R10 first");
    after_done("R10 first", 140, 3, 0);
    run("R10 again");
    after_done("R10 rerun", 140, 3, 0);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single();
    t_expr();
    t_inherit();
    t_circular();
    t_expr();
    t_limit();
    t_wrap();
    t_circular();
    t_rerun();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule